// File: doc/BRIEF.md
# Table branch execution unit

This block carries out one kind of 32-bit instruction: a forward branch whose distance comes from a table in memory. The instruction word names a base register and an index register. The unit reads both registers through a register-file read port. It adds the index to the base, either unscaled or doubled, to find a table entry. It then fetches either a single unsigned byte or a little-endian unsigned halfword and branches forward by twice that value, measured from the program counter.

A pipeline hands the unit an instruction word, the instruction's address, and three facts it decides elsewhere: whether the condition passed, whether the instruction sits in a conditional block, and whether it is the last one there. The unit retires each accepted instruction with a one-cycle `retire` pulse. If the instruction executes, `branch_valid` and the target come with that pulse. When the encoding or the context is unpredictable, a flag is raised in the same cycle.

Top module: `tbr_unit`

## Requirements
- R1: An instruction is recognised only when bits 31:20 equal 111010001101 and bits 7:5 equal 000. For any other word, `retire` pulses in the cycle after acceptance, and there is no memory request, no branch and no flag.
- R2: With bit 4 clear (byte variant), the table address is base plus index. The request has `mem_size` 0, and the fetched value is `mem_rdata[7:0]` taken as unsigned; the upper byte lane is ignored.
- R3: With bit 4 set (halfword variant), the table address is base plus twice the index. The request has `mem_size` 1, and the value is `{mem_rdata[15:8], mem_rdata[7:0]}`, with the byte at the lower address in bits 7:0.
- R4: The program counter value is the instruction address plus 4 with bit 0 cleared. The target is that value plus twice the fetched entry, modulo 2^XLEN.
- R5: When bits 19:16 equal 15, the base is the program counter value and not the register-file data.
- R6: With `cond_pass` low, a recognised instruction retires in the next cycle with no memory request and no branch.
- R7: If bits 15:12 are not all ones or bits 11:8 are not all zeros, `unpred` is high with `retire`, and the branch still takes place.
- R8: An index register number of 15 raises `unpred` with `retire` and suppresses the memory request and the branch.
- R9: With `in_it` high and `last_in_it` low, `unpred` is high with `retire` and the branch still takes place. With both high, no flag is raised.
- R10: `mem_req` rises in the cycle after acceptance and stays high, with `mem_addr` and `mem_size` unchanged, until `mem_rvalid` is sampled. `busy` is high over that span, and `start` is ignored while `busy` is high.
- R11: `branch_valid` is a one-cycle pulse that coincides with `retire`. `br_kind` reads 2'b10 (indirect) in that cycle and 2'b00 at all other times.
- R12: A synchronous high `rst` abandons any fetch in progress and leaves `mem_req`, `busy`, `retire`, `branch_valid` and `unpred` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction offered this cycle |
| instr | input | 32 | Instruction word |
| instr_addr | input | XLEN | Address of the instruction |
| cond_pass | input | 1 | Condition evaluated true |
| in_it | input | 1 | Instruction lies in a conditional block |
| last_in_it | input | 1 | Instruction is last in that block |
| rf_raddr_a | output | 4 | Register number for the base read |
| rf_rdata_a | input | XLEN | Base register data |
| rf_raddr_b | output | 4 | Register number for the index read |
| rf_rdata_b | input | XLEN | Index register data |
| mem_req | output | 1 | Table read request, held until response |
| mem_addr | output | XLEN | Table entry address |
| mem_size | output | 1 | 0 byte, 1 halfword |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data, lower address in bits 7:0 |
| busy | output | 1 | Fetch outstanding |
| retire | output | 1 | Instruction completes this cycle |
| branch_valid | output | 1 | Redirect this cycle |
| branch_target | output | XLEN | Redirect address |
| br_kind | output | 2 | 2'b10 indirect on redirect, else 2'b00 |
| unpred | output | 1 | Unpredictable case, valid with retire |

## Verification
The branch completion and the unpredictable report can land in the same retire cycle. The bench provokes this with encodings whose should-be-one or should-be-zero bits are wrong, and with an instruction placed inside a conditional block but not last in it. In the cycle after the memory response, it samples `retire`, `branch_valid`, the target and `unpred` together and expects all of them to hold at once. The same cycle-alignment check runs against the index-15 case, where the flag must appear with no branch at all. It also runs against the case of the last instruction in the block, where the branch must appear with no flag.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

    localparam int unsigned INSN_W  = 32;
    localparam int unsigned RNUM_W  = 4;
    localparam int unsigned ENTRY_W = 16;

    localparam logic [11:0]       TB_MAJOR = 12'b1110_1000_1101;
    localparam logic [2:0]        TB_MID   = 3'b000;
    localparam logic [3:0]        TB_ONES  = 4'hF;
    localparam logic [3:0]        TB_ZEROS = 4'h0;
    localparam logic [RNUM_W-1:0] PC_NUM   = 4'd15;

    typedef enum logic [1:0] {
        BR_NONE     = 2'b00,
        BR_DIRECT   = 2'b01,
        BR_INDIRECT = 2'b10
    } br_kind_e;

    typedef enum logic {
        TBL_BYTE = 1'b0,
        TBL_HALF = 1'b1
    } tbl_size_e;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_WAIT = 1'b1
    } fetch_state_e;

    typedef struct packed {
        logic              is_tb;
        logic [RNUM_W-1:0] rn;
        logic [RNUM_W-1:0] rm;
        tbl_size_e         size;
        logic              sb_bad;
        logic              rm_pc;
    } tb_dec_t;

    function automatic tb_dec_t tb_decode(input logic [INSN_W-1:0] w);
        tb_dec_t d;
        d.is_tb  = (w[31:20] == TB_MAJOR) && (w[7:5] == TB_MID);
        d.rn     = w[19:16];
        d.rm     = w[3:0];
        d.size   = w[4] ? TBL_HALF : TBL_BYTE;
        d.sb_bad = (w[15:12] != TB_ONES) || (w[11:8] != TB_ZEROS);
        d.rm_pc  = (w[3:0] == PC_NUM);
        return d;
    endfunction

    // Zero-extends a byte entry; a halfword is assembled low byte first.
    function automatic logic [ENTRY_W-1:0] tb_entry(input tbl_size_e sz,
                                                    input logic [ENTRY_W-1:0] lanes);
        logic [ENTRY_W-1:0] v;
        if (sz == TBL_HALF) v = {lanes[15:8], lanes[7:0]};
        else                v = {8'h00, lanes[7:0]};
        return v;
    endfunction

endpackage

// File: rtl/tbr_decode.sv
module tbr_decode
    import tbr_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    input  logic              in_it,
    input  logic              last_in_it,
    output tb_dec_t           dec,
    output logic              unpred
);

    tb_dec_t d;

    always_comb begin
        d      = tb_decode(instr);
        dec    = d;
        unpred = d.is_tb && (d.sb_bad || d.rm_pc || (in_it && !last_in_it));
    end

endmodule

// File: rtl/tbr_addr_gen.sv
module tbr_addr_gen
    import tbr_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] instr_addr,
    input  logic            base_is_pc,
    input  tbl_size_e       size,
    input  logic [XLEN-1:0] rf_base,
    input  logic [XLEN-1:0] rf_index,
    output logic [XLEN-1:0] pc_val,
    output logic [XLEN-1:0] tbl_addr
);

    localparam logic [XLEN-1:0] PC_AHEAD = XLEN'(4);
    localparam logic [XLEN-1:0] LSB_MASK = ~(XLEN'(1));

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        pc_val   = (instr_addr + PC_AHEAD) & LSB_MASK;
        base     = base_is_pc ? pc_val : rf_base;
        offset   = (size == TBL_HALF) ? {rf_index[XLEN-2:0], 1'b0} : rf_index;
        tbl_addr = base + offset;
    end

endmodule

// File: rtl/tbr_fetch.sv
module tbr_fetch
    import tbr_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               launch,
    input  logic               exec,
    input  logic               unpred_in,
    input  tbl_size_e          size,
    input  logic [XLEN-1:0]    tbl_addr,
    input  logic [XLEN-1:0]    pc_val,
    output logic               mem_req,
    output logic [XLEN-1:0]    mem_addr,
    output logic               mem_size,
    input  logic               mem_rvalid,
    input  logic [ENTRY_W-1:0] mem_rdata,
    output logic               busy,
    output logic               retire,
    output logic               branch_valid,
    output logic [XLEN-1:0]    branch_target,
    output br_kind_e           br_kind,
    output logic               unpred
);

    localparam int unsigned PAD_W = XLEN - ENTRY_W - 1;

    fetch_state_e       state_q;
    logic               req_q;
    logic [XLEN-1:0]    addr_q;
    tbl_size_e          size_q;
    logic [XLEN-1:0]    pc_q;
    logic               unp_hold_q;
    logic               retire_q;
    logic               brv_q;
    logic [XLEN-1:0]    tgt_q;
    logic               unp_out_q;
    logic [ENTRY_W-1:0] entry;
    logic [XLEN-1:0]    span;
    logic [XLEN-1:0]    tgt_next;

    always_comb begin
        entry    = tb_entry(size_q, mem_rdata);
        span     = {{PAD_W{1'b0}}, entry, 1'b0};
        tgt_next = pc_q + span;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= FS_IDLE;
            req_q      <= 1'b0;
            addr_q     <= '0;
            size_q     <= TBL_BYTE;
            pc_q       <= '0;
            unp_hold_q <= 1'b0;
            retire_q   <= 1'b0;
            brv_q      <= 1'b0;
            tgt_q      <= '0;
            unp_out_q  <= 1'b0;
        end else begin
            retire_q  <= 1'b0;
            brv_q     <= 1'b0;
            unp_out_q <= 1'b0;
            case (state_q)
                FS_IDLE: begin
                    if (launch) begin
                        if (exec) begin
                            state_q    <= FS_WAIT;
                            req_q      <= 1'b1;
                            addr_q     <= tbl_addr;
                            size_q     <= size;
                            pc_q       <= pc_val;
                            unp_hold_q <= unpred_in;
                        end else begin
                            retire_q  <= 1'b1;
                            unp_out_q <= unpred_in;
                        end
                    end
                end
                FS_WAIT: begin
                    if (mem_rvalid) begin
                        state_q   <= FS_IDLE;
                        req_q     <= 1'b0;
                        retire_q  <= 1'b1;
                        brv_q     <= 1'b1;
                        tgt_q     <= tgt_next;
                        unp_out_q <= unp_hold_q;
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req       = req_q;
        mem_addr      = addr_q;
        mem_size      = (size_q == TBL_HALF);
        busy          = (state_q == FS_WAIT);
        retire        = retire_q;
        branch_valid  = brv_q;
        branch_target = tgt_q;
        br_kind       = brv_q ? BR_INDIRECT : BR_NONE;
        unpred        = unp_out_q;
    end

    // R10: request, address and size hold until the response arrives
    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && $stable(mem_size)));

    // R10: a response ends the request
    a_r10_req_drop: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_rvalid) |=> !mem_req);

    // R11: redirect lasts exactly one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        branch_valid |=> !branch_valid);

    // R11: redirect only alongside retirement
    a_r11_with_retire: assert property (@(posedge clk) disable iff (rst)
        branch_valid |-> retire);

endmodule

// File: rtl/tbr_unit.sv
module tbr_unit
    import tbr_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [INSN_W-1:0]  instr,
    input  logic [XLEN-1:0]    instr_addr,
    input  logic               cond_pass,
    input  logic               in_it,
    input  logic               last_in_it,
    output logic [RNUM_W-1:0]  rf_raddr_a,
    input  logic [XLEN-1:0]    rf_rdata_a,
    output logic [RNUM_W-1:0]  rf_raddr_b,
    input  logic [XLEN-1:0]    rf_rdata_b,
    output logic               mem_req,
    output logic [XLEN-1:0]    mem_addr,
    output logic               mem_size,
    input  logic               mem_rvalid,
    input  logic [ENTRY_W-1:0] mem_rdata,
    output logic               busy,
    output logic               retire,
    output logic               branch_valid,
    output logic [XLEN-1:0]    branch_target,
    output logic [1:0]         br_kind,
    output logic               unpred
);

    tb_dec_t         dec;
    logic            dec_unpred;
    logic [XLEN-1:0] pc_val;
    logic [XLEN-1:0] tbl_addr;
    logic            launch;
    logic            exec;
    br_kind_e        kind;

    tbr_decode u_decode (
        .instr      (instr),
        .in_it      (in_it),
        .last_in_it (last_in_it),
        .dec        (dec),
        .unpred     (dec_unpred)
    );

    assign rf_raddr_a = dec.rn;
    assign rf_raddr_b = dec.rm;

    tbr_addr_gen #(.XLEN(XLEN)) u_addr (
        .instr_addr (instr_addr),
        .base_is_pc (dec.rn == PC_NUM),
        .size       (dec.size),
        .rf_base    (rf_rdata_a),
        .rf_index   (rf_rdata_b),
        .pc_val     (pc_val),
        .tbl_addr   (tbl_addr)
    );

    assign launch = start && !busy;
    assign exec   = dec.is_tb && cond_pass && !dec.rm_pc;

    tbr_fetch #(.XLEN(XLEN)) u_fetch (
        .clk           (clk),
        .rst           (rst),
        .launch        (launch),
        .exec          (exec),
        .unpred_in     (dec_unpred),
        .size          (dec.size),
        .tbl_addr      (tbl_addr),
        .pc_val        (pc_val),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_size      (mem_size),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .busy          (busy),
        .retire        (retire),
        .branch_valid  (branch_valid),
        .branch_target (branch_target),
        .br_kind       (kind),
        .unpred        (unpred)
    );

    assign br_kind = kind;

    // R1: an unrecognised word never reaches memory and raises no flag
    a_r1_foreign_word: assert property (@(posedge clk) disable iff (rst)
        (launch && !dec.is_tb) |=> (!mem_req && retire && !unpred));

    // R6: a failed condition retires without a fetch
    a_r6_cond_fail: assert property (@(posedge clk) disable iff (rst)
        (launch && !cond_pass) |=> (!mem_req && retire && !branch_valid));

    // R8: index number 15 flags and suppresses the fetch
    a_r8_index_pc: assert property (@(posedge clk) disable iff (rst)
        (launch && dec.is_tb && dec.rm_pc) |=> (!mem_req && unpred && !branch_valid));

endmodule

// File: tb/tb_tbr_unit.sv
`timescale 1ns/1ps
module tb_tbr_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] instr;
    logic [31:0] instr_addr;
    logic        cond_pass, in_it, last_in_it;
    logic [3:0]  rf_raddr_a, rf_raddr_b;
    logic [31:0] rf_rdata_a, rf_rdata_b;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_size;
    logic        mem_rvalid;
    logic [15:0] mem_rdata;
    logic        busy, retire, branch_valid;
    logic [31:0] branch_target;
    logic [1:0]  br_kind;
    logic        unpred;

    logic [31:0] rf [16];
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    assign rf_rdata_a = rf[rf_raddr_a];
    assign rf_rdata_b = rf[rf_raddr_b];

    tbr_unit dut (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .instr_addr(instr_addr),
        .cond_pass(cond_pass), .in_it(in_it), .last_in_it(last_in_it),
        .rf_raddr_a(rf_raddr_a), .rf_rdata_a(rf_rdata_a),
        .rf_raddr_b(rf_raddr_b), .rf_rdata_b(rf_rdata_b),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .retire(retire), .branch_valid(branch_valid),
        .branch_target(branch_target), .br_kind(br_kind), .unpred(unpred)
    );

    function automatic logic [31:0] mk(input logic [11:0] top, input logic [3:0] rn,
                                       input logic [3:0] ones, input logic [3:0] zeros,
                                       input logic [2:0] mid, input logic h,
                                       input logic [3:0] rm);
        return {top, rn, ones, zeros, mid, h, rm};
    endfunction

    function automatic logic [7:0] fb(input logic [31:0] a);
        return a[7:0] ^ {a[3:0], a[7:4]} ^ 8'hA5;
    endfunction

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] iaddr;
        logic [31:0] rn_val;
        logic [31:0] rm_val;
        logic        cond;
        logic        it;
        logic        last;
        logic [1:0]  lat;
        logic        exp_req;
        logic        exp_unp;
        logic [3:0]  rid;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{mk(12'hE8D, 4'd2,  4'hF, 4'h0, 3'd0, 1'b0, 4'd3),  32'h0000_0100, 32'h0000_1000, 32'd5,    1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 4'd2},  // R2
        '{mk(12'hE8D, 4'd4,  4'hF, 4'h0, 3'd0, 1'b1, 4'd1),  32'h0000_0200, 32'h0000_2000, 32'd7,    1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 4'd3},  // R3
        '{mk(12'hE8D, 4'd15, 4'hF, 4'h0, 3'd0, 1'b1, 4'd6),  32'h0000_0301, 32'hDEAD_BEEF, 32'd3,    1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 4'd5},  // R5, R4 odd address
        '{mk(12'hE8D, 4'd15, 4'hF, 4'h0, 3'd0, 1'b0, 4'd2),  32'h0000_0400, 32'hDEAD_BEEF, 32'h11,   1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 4'd5},  // R5
        '{mk(12'hE8D, 4'd1,  4'hF, 4'h0, 3'd0, 1'b0, 4'd2),  32'h0000_0480, 32'h0000_0900, 32'd1,    1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd6},  // R6
        '{mk(12'hE8D, 4'd1,  4'hE, 4'h0, 3'd0, 1'b0, 4'd2),  32'h0000_0500, 32'h0000_3000, 32'd9,    1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 4'd7},  // R7 ones field
        '{mk(12'hE8D, 4'd1,  4'hF, 4'h1, 3'd0, 1'b1, 4'd2),  32'h0000_0600, 32'h0000_3100, 32'd4,    1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 4'd7},  // R7 zeros field
        '{mk(12'hE8D, 4'd1,  4'hF, 4'h0, 3'd0, 1'b0, 4'd15), 32'h0000_0700, 32'h0000_3200, 32'd2,    1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 4'd8},  // R8
        '{mk(12'hE8D, 4'd5,  4'hF, 4'h0, 3'd0, 1'b0, 4'd6),  32'h0000_0800, 32'h0000_4000, 32'h20,   1'b1, 1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 4'd9},  // R9 not last
        '{mk(12'hE8D, 4'd5,  4'hF, 4'h0, 3'd0, 1'b0, 4'd6),  32'h0000_0900, 32'h0000_4000, 32'h21,   1'b1, 1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 4'd9},  // R9 last
        '{mk(12'hE8C, 4'd5,  4'hF, 4'h0, 3'd0, 1'b0, 4'd6),  32'h0000_0A00, 32'h0000_4000, 32'h22,   1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd1},  // R1 major
        '{mk(12'hE8D, 4'd5,  4'hF, 4'h0, 3'd1, 1'b0, 4'd6),  32'h0000_0B00, 32'h0000_4000, 32'h23,   1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd1},  // R1 mid
        '{mk(12'hE8D, 4'd5,  4'hF, 4'h0, 3'd0, 1'b1, 4'd15), 32'h0000_0C00, 32'h0000_4000, 32'h24,   1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 4'd8},  // R8 with R6
        '{mk(12'hE8D, 4'd7,  4'hF, 4'h0, 3'd0, 1'b1, 4'd8),  32'h0000_0D00, 32'hFFFF_FFF0, 32'h10,   1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 4'd3},  // R3 address wrap
        '{mk(12'hE8D, 4'd9,  4'hF, 4'h0, 3'd0, 1'b0, 4'd10), 32'hFFFF_FF00, 32'h0000_0080, 32'h7F,   1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 4'd4}   // R4 target wrap
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic [31:0] ia, input logic c,
                         input logic it, input logic lst);
        @(negedge clk);
        start = 1'b1; instr = w; instr_addr = ia;
        cond_pass = c; in_it = it; last_in_it = lst;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        logic [31:0] pcv, eaddr, eval, etgt;
        logic [3:0]  rn, rm;
        logic        h;
        string       rq;
        rq = $sformatf("R%0d", v.rid);
        rn = v.instr[19:16]; rm = v.instr[3:0]; h = v.instr[4];
        rf[rn] = v.rn_val;
        rf[rm] = v.rm_val;
        pcv   = (v.iaddr + 32'd4) & ~32'd1;
        eaddr = ((rn == 4'd15) ? pcv : v.rn_val) + (h ? {v.rm_val[30:0], 1'b0} : v.rm_val);
        issue(v.instr, v.iaddr, v.cond, v.it, v.last);
        chk(rq, {31'd0, mem_req}, {31'd0, v.exp_req});
        if (v.exp_req) begin
            chk(rq, mem_addr, eaddr);
            chk(rq, {31'd0, mem_size}, {31'd0, h});
            chk("R10", {31'd0, busy}, 32'd1);
            for (int i = 0; i < int'(v.lat); i++) begin
                @(negedge clk);
                chk("R10", {31'd0, mem_req}, 32'd1);
            end
            eval = h ? {16'd0, fb(eaddr + 32'd1), fb(eaddr)} : {24'd0, fb(eaddr)};
            mem_rdata  = h ? {fb(eaddr + 32'd1), fb(eaddr)} : {~fb(eaddr), fb(eaddr)};
            mem_rvalid = 1'b1;
            @(negedge clk);
            mem_rvalid = 1'b0;
            mem_rdata  = 16'h0000;
            etgt = pcv + {eval[30:0], 1'b0};
            chk("R11", {31'd0, retire}, 32'd1);
            chk("R11", {31'd0, branch_valid}, 32'd1);
            chk($sformatf("R4 via %s", rq), branch_target, etgt);
            chk("R11", {30'd0, br_kind}, 32'd2);
            chk(rq, {31'd0, unpred}, {31'd0, v.exp_unp});
            @(negedge clk);
            chk("R11", {31'd0, branch_valid}, 32'd0);
            chk("R10", {31'd0, mem_req}, 32'd0);
        end else begin
            chk(rq, {31'd0, retire}, 32'd1);
            chk(rq, {31'd0, branch_valid}, 32'd0);
            chk(rq, {31'd0, unpred}, {31'd0, v.exp_unp});
            chk("R11", {30'd0, br_kind}, 32'd0);
            @(negedge clk);
            chk(rq, {31'd0, retire}, 32'd0);
            chk(rq, {31'd0, mem_req}, 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 32'h0;
        rst = 1'b1; start = 1'b0; instr = '0; instr_addr = '0;
        cond_pass = 1'b0; in_it = 1'b0; last_in_it = 1'b0;
        mem_rvalid = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12: state after reset
        chk("R12", {31'd0, mem_req}, 32'd0);
        chk("R12", {31'd0, busy}, 32'd0);
        chk("R12", {31'd0, retire}, 32'd0);
        chk("R12", {31'd0, branch_valid}, 32'd0);
        chk("R12", {31'd0, unpred}, 32'd0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R10: start held while busy is ignored
        rf[2] = 32'h0000_5000; rf[3] = 32'd6; rf[8] = 32'h0000_9000;
        issue(mk(12'hE8D, 4'd2, 4'hF, 4'h0, 3'd0, 1'b0, 4'd3), 32'h0000_1000, 1'b1, 1'b0, 1'b0);
        start = 1'b1;
        instr = mk(12'hE8D, 4'd8, 4'hF, 4'h0, 3'd0, 1'b0, 4'd3);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R10", mem_addr, 32'h0000_5006);
            chk("R10", {31'd0, busy}, 32'd1);
        end
        start = 1'b0;
        mem_rdata = {8'hEE, 8'h10}; mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk("R10", branch_target, 32'h0000_1024);
        @(negedge clk);
        chk("R10", {31'd0, mem_req}, 32'd0);
        chk("R10", {31'd0, retire}, 32'd0);

        // R12: reset during an outstanding fetch
        issue(mk(12'hE8D, 4'd2, 4'hF, 4'h0, 3'd0, 1'b1, 4'd3), 32'h0000_2000, 1'b1, 1'b0, 1'b0);
        chk("R12", {31'd0, mem_req}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R12", {31'd0, mem_req}, 32'd0);
        chk("R12", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R12", {31'd0, retire}, 32'd0);
        chk("R12", {31'd0, branch_valid}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule